// File: doc/BRIEF.md
# Coalescing Interrupt Controller

This block gathers 31 single-cycle event pulses from a packet DMA engine and drives one level-sensitive interrupt line. Each event is caught in a raw status register. Software clears a raw bit by writing a one to it. An enable mask selects which raw bits can reach the line, and a masked view shows the bits that are currently asserting it.

Two completion streams, receive-queue-in and transmit-reclaim-in, do not set their raw bits directly. Each one passes through a coalescer. The coalescer counts completions and sets the completion bit once the count reaches a programmed threshold. If completions are still waiting when a programmed cycle budget runs out, it sets a dedicated timeout bit instead. Either outcome empties that stream's pending count and its timer. Software therefore gets one interrupt per burst, with a bounded delay for a burst that stays short of the threshold.

All registers sit on a simple register port. A write takes effect on the clock edge where `wr_en_i` is sampled high. Reads are combinational from `rd_addr_i`.

Top module: `irqc_coalesce_top`

## Requirements
- R1: An event pulse on any input bit other than 17, 19, 28 and 29 sets the same bit of the raw register (address 0) on the clock edge that samples it. The bit then stays set until software clears it.
- R2: Writing to address 0 clears every raw bit that has a one in the write data. Bits written with zero keep their value. When a bit is set and cleared on the same edge, the set wins.
- R3: Address 2 reads raw AND enable. The enable mask lives at address 1, with bit n gating raw bit n. `irq_o` is high exactly when that masked value is nonzero.
- R4: Writing zero to the enable register drives `irq_o` low from the next cycle on. The raw register is left unchanged.
- R5: Address 3 holds the receive count threshold in bits 15:0 and the transmit count threshold in bits 31:16. Completion pulses arrive on event input 17 (receive) and 19 (transmit). The edge that samples the completion that brings the pending count up to the threshold sets raw bit 17 or 19 respectively.
- R6: A count threshold of 1 sets the completion raw bit on every single completion. A threshold of 0 behaves the same as 1.
- R7: The receive timeout budget T is at address 4 and the transmit budget at address 5. Suppose a completion is sampled on edge k, leaves the count below threshold, and no threshold hit follows. Then raw bit 28 (receive) or 29 (transmit) is set on edge k+T and not earlier. A budget of 0 disables the timeout.
- R8: A threshold hit or a timeout clears that stream's pending count and timer. Completions counted before the hit never contribute to a later hit, and no timeout follows a hit unless new completions arrive.
- R9: Pulses on event inputs 28 and 29 never set raw bits. Pulses on 17 and 19 act only as completions. Bit 31 of the raw, enable and masked registers always reads zero.
- R10: After reset the raw and enable registers read zero. Address 3 reads 0x00010001, address 4 reads 0x00010000 and address 5 reads 0x00050000. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 31 | Event pulses; bits 17 and 19 are completions |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that an event input is one pulse per sampled cycle: a level held high counts as one completion on every edge. They also assume that configuration may change at any time, including while completions are pending. The stimulus draws sparse random pulses with denser completion traffic, and makes random writes to every register using small thresholds and budgets so that both the count path and the timeout path fire often. Directed sequences pin down the exact timeout edge, a set and a clear on the same edge, and the threshold values 0 and 1.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned ADDR_W       = 3;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned NQ           = 2;
  localparam int unsigned RX_IN_BIT    = 17;
  localparam int unsigned TX_IN_BIT    = 19;
  localparam int unsigned RX_TMO_BIT   = 28;
  localparam int unsigned TX_TMO_BIT   = 29;
  localparam int unsigned TX_THR_SHIFT = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW     = 3'd0,
    REG_ENA     = 3'd1,
    REG_MASKED  = 3'd2,
    REG_CNT_THR = 3'd3,
    REG_RX_TMO  = 3'd4,
    REG_TX_TMO  = 3'd5
  } irqc_reg_e;
endpackage

// File: rtl/irqc_coalescer.sv
module irqc_coalescer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl_i,
  input  logic [CNT_W-1:0] cnt_thr_i,
  input  logic [TMO_W-1:0] tmo_thr_i,
  output logic             fire_cnt_o,
  output logic             fire_tmo_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);
  localparam logic [TMO_W-1:0] TMO_MAX = '1;

  logic [CNT_W-1:0] pend_q, pend_d, pend_inc, eff_thr;
  logic [TMO_W-1:0] tmr_q, tmr_d, tmr_inc;
  logic             pending, hit_cnt, hit_tmo, upd;

  // next-state: count path has priority over the timeout path
  always_comb begin
    eff_thr  = (cnt_thr_i == '0) ? CNT_ONE : cnt_thr_i;
    pend_inc = pend_q + (cmpl_i ? CNT_ONE : '0);
    pending  = (pend_q != '0);
    tmr_inc  = (tmr_q == TMO_MAX) ? tmr_q : tmr_q + TMO_ONE;
    hit_cnt  = cmpl_i && (pend_inc >= eff_thr);
    hit_tmo  = pending && !hit_cnt && (tmo_thr_i != '0) && (tmr_inc >= tmo_thr_i);
    upd      = cmpl_i || pending;
    if (hit_cnt || hit_tmo) begin
      pend_d = '0;
      tmr_d  = '0;
    end else begin
      pend_d = pend_inc;
      tmr_d  = pending ? tmr_inc : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tmr_q  <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
    end
  end

  assign fire_cnt_o = hit_cnt;
  assign fire_tmo_o = hit_tmo;

  AST_FIRE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire_cnt_o && fire_tmo_o)); // R8
  AST_TMO_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fire_tmo_o |-> (pend_q != '0)); // R7
  AST_FIRE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_cnt_o || fire_tmo_o) |=> (pend_q == '0 && tmr_q == '0)); // R8
endmodule

// File: rtl/irqc_raw_status.sv
module irqc_raw_status #(
  parameter int unsigned NSRC = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_we_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] raw_o
);
  logic [NSRC-1:0] raw_q, raw_d, clr_eff;
  logic            upd;

  // set is applied after clear, so a same-edge set wins
  always_comb begin
    clr_eff = clr_we_i ? clr_i : '0;
    raw_d   = (raw_q & ~clr_eff) | set_i;
    upd     = clr_we_i || (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else if (upd) raw_q <= raw_d;
  end

  assign raw_o = raw_q;

  for (genvar b = 0; b < NSRC; b++) begin : g_chk
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> raw_q[b]); // R1
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we_i && clr_i[b] && !set_i[b]) |=> !raw_q[b]); // R2
    AST_HOLD_UNLESS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[b] && !(clr_we_i && clr_i[b])) |=> raw_q[b]); // R2
  end
endmodule

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC       = 31,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TMO_W      = 32,
  parameter int unsigned RX_TMO_RST = 32'h0001_0000,
  parameter int unsigned TX_TMO_RST = 32'h0005_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NSRC-1:0]   ena_o,
  output logic [CNT_W-1:0]  rx_cthr_o,
  output logic [CNT_W-1:0]  tx_cthr_o,
  output logic [TMO_W-1:0]  rx_tmo_o,
  output logic [TMO_W-1:0]  tx_tmo_o
);
  logic [NSRC-1:0]  ena_q;
  logic [CNT_W-1:0] rx_cthr_q, tx_cthr_q;
  logic [TMO_W-1:0] rx_tmo_q, tx_tmo_q;
  logic             we_ena, we_cthr, we_rx_tmo, we_tx_tmo;

  always_comb begin
    we_ena    = wr_en_i && (wr_addr_i == REG_ENA);
    we_cthr   = wr_en_i && (wr_addr_i == REG_CNT_THR);
    we_rx_tmo = wr_en_i && (wr_addr_i == REG_RX_TMO);
    we_tx_tmo = wr_en_i && (wr_addr_i == REG_TX_TMO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ena_q <= '0;
    else if (we_ena) ena_q <= wr_data_i[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cthr_q <= CNT_W'(1);
      tx_cthr_q <= CNT_W'(1);
    end else if (we_cthr) begin
      rx_cthr_q <= wr_data_i[CNT_W-1:0];
      tx_cthr_q <= wr_data_i[TX_THR_SHIFT +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_tmo_q <= TMO_W'(RX_TMO_RST);
    else if (we_rx_tmo) rx_tmo_q <= wr_data_i[TMO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_tmo_q <= TMO_W'(TX_TMO_RST);
    else if (we_tx_tmo) tx_tmo_q <= wr_data_i[TMO_W-1:0];
  end

  assign ena_o     = ena_q;
  assign rx_cthr_o = rx_cthr_q;
  assign tx_cthr_o = tx_cthr_q;
  assign rx_tmo_o  = rx_tmo_q;
  assign tx_tmo_o  = tx_tmo_q;

  AST_CTHR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_cthr |=> (rx_cthr_o == $past(wr_data_i[CNT_W-1:0]))); // R5
endmodule

// File: rtl/irqc_coalesce_top.sv
module irqc_coalesce_top
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC       = 31,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned TMO_W      = 32,
  parameter int unsigned RX_TMO_RST = 32'h0001_0000,
  parameter int unsigned TX_TMO_RST = 32'h0005_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned IN_BIT  [NQ] = '{RX_IN_BIT, TX_IN_BIT};
  localparam int unsigned TMO_BIT [NQ] = '{RX_TMO_BIT, TX_TMO_BIT};

  logic [NSRC-1:0]  raw, ena, masked, set_vec;
  logic [CNT_W-1:0] cthr [NQ];
  logic [TMO_W-1:0] tmo  [NQ];
  logic [NQ-1:0]    fire_cnt, fire_tmo;
  logic             clr_we;

  irqc_cfg_regs #(
    .NSRC(NSRC), .CNT_W(CNT_W), .TMO_W(TMO_W),
    .RX_TMO_RST(RX_TMO_RST), .TX_TMO_RST(TX_TMO_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ena_o(ena),
    .rx_cthr_o(cthr[0]), .tx_cthr_o(cthr[1]),
    .rx_tmo_o(tmo[0]), .tx_tmo_o(tmo[1])
  );

  for (genvar q = 0; q < NQ; q++) begin : g_coal
    irqc_coalescer #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_coal (
      .clk(clk), .rst_n(rst_n),
      .cmpl_i(evt_i[IN_BIT[q]]),
      .cnt_thr_i(cthr[q]), .tmo_thr_i(tmo[q]),
      .fire_cnt_o(fire_cnt[q]), .fire_tmo_o(fire_tmo[q])
    );
  end

  // coalesced positions take their set from the coalescers only
  always_comb begin
    set_vec = evt_i;
    for (int q = 0; q < int'(NQ); q++) begin
      set_vec[IN_BIT[q]]  = fire_cnt[q];
      set_vec[TMO_BIT[q]] = fire_tmo[q];
    end
    clr_we = wr_en_i && (wr_addr_i == REG_RAW);
  end

  irqc_raw_status #(.NSRC(NSRC)) u_raw (
    .clk(clk), .rst_n(rst_n),
    .set_i(set_vec), .clr_we_i(clr_we), .clr_i(wr_data_i[NSRC-1:0]),
    .raw_o(raw)
  );

  assign masked = raw & ena;
  assign irq_o  = |masked;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_RAW:     rd_data_o[NSRC-1:0] = raw;
      REG_ENA:     rd_data_o[NSRC-1:0] = ena;
      REG_MASKED:  rd_data_o[NSRC-1:0] = masked;
      REG_CNT_THR: begin
        rd_data_o[CNT_W-1:0]               = cthr[0];
        rd_data_o[TX_THR_SHIFT +: CNT_W]   = cthr[1];
      end
      REG_RX_TMO:  rd_data_o[TMO_W-1:0] = tmo[0];
      REG_TX_TMO:  rd_data_o[TMO_W-1:0] = tmo[1];
      default:     rd_data_o = '0;
    endcase
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ena == '0) |-> !irq_o); // R4
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|raw)); // R3
  AST_ENA_WRITE_KEEPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == REG_ENA && set_vec == '0) |=> $stable(raw)); // R4
  AST_DIRECT_TMO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_tmo == '0 && !clr_we && !raw[RX_TMO_BIT]) |=> !raw[RX_TMO_BIT]); // R9
endmodule

// File: tb/irqc_coalesce_top_tb.sv
module irqc_coalesce_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [30:0] evt;
  logic        wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [30:0] m_raw, m_en;
  int unsigned m_cthr [2];
  int unsigned m_tmo  [2];
  int unsigned m_pend [2];
  int unsigned m_tmr  [2];

  always #2 clk = ~clk;

  irqc_coalesce_top u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_raw};
      3'd1: return {1'b0, m_en};
      3'd2: return {1'b0, m_raw & m_en};
      3'd3: return {m_cthr[1][15:0], m_cthr[0][15:0]};
      3'd4: return m_tmo[0];
      3'd5: return m_tmo[1];
      default: return 32'h0;
    endcase
  endfunction

  // reference coalescer from R5..R8
  task automatic coal_model(input int q, input bit c, output bit fc, output bit ft);
    int unsigned th = (m_cthr[q] == 0) ? 1 : m_cthr[q];
    int unsigned p  = m_pend[q] + (c ? 1 : 0);
    fc = c && (p >= th);
    ft = 0;
    if (fc) begin
      m_pend[q] = 0; m_tmr[q] = 0;
    end else if (m_pend[q] != 0 && m_tmo[q] != 0 && m_tmr[q] + 1 >= m_tmo[q]) begin
      ft = 1; m_pend[q] = 0; m_tmr[q] = 0;
    end else begin
      m_tmr[q]  = (m_pend[q] != 0) ? m_tmr[q] + 1 : 0;
      m_pend[q] = p;
    end
  endtask

  task automatic step(input logic [30:0] ev, input logic we, input logic [2:0] wa,
                      input logic [31:0] wd, input logic [2:0] ra, input string tag);
    logic [30:0] setv;
    bit fc0, ft0, fc1, ft1;
    evt = ev; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    coal_model(0, ev[17], fc0, ft0);
    coal_model(1, ev[19], fc1, ft1);
    setv = ev;
    setv[17] = fc0; setv[19] = fc1; setv[28] = ft0; setv[29] = ft1;
    if (we && wa == 3'd0) m_raw = m_raw & ~wd[30:0];
    m_raw = m_raw | setv;
    if (we) begin
      case (wa)
        3'd1: m_en = wd[30:0];
        3'd3: begin m_cthr[0] = wd[15:0]; m_cthr[1] = wd[31:16]; end
        3'd4: m_tmo[0] = wd;
        3'd5: m_tmo[1] = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    chk({tag, " read"}, rd_data, exp_read(ra));
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_raw & m_en)});
  endtask

  task automatic idle(input int n, input logic [2:0] ra, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, 3'd0, 32'h0, ra, tag);
  endtask

  task automatic clear_raw();
    step('0, 1'b1, 3'd0, 32'hFFFF_FFFF, 3'd0, "R2 clear");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_raw = '0; m_en = '0;
    m_cthr[0] = 1; m_cthr[1] = 1; m_tmo[0] = 32'h1_0000; m_tmo[1] = 32'h5_0000;
    m_pend[0] = 0; m_pend[1] = 0; m_tmr[0] = 0; m_tmr[1] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset values
    for (int a = 0; a < 8; a++) begin
      logic [31:0] e;
      rd_addr = 3'(a);
      #1;
      case (a)
        3: e = 32'h0001_0001;
        4: e = 32'h0001_0000;
        5: e = 32'h0005_0000;
        default: e = 32'h0;
      endcase
      chk("R10 reset value", rd_data, e);
    end
    chk("R10 reset irq", {31'h0, irq}, 32'h0);
    @(negedge clk);

    // R1 direct sources latch and hold
    step(31'h4000_0008, 1'b0, 3'd0, 32'h0, 3'd0, "R1");
    idle(3, 3'd0, "R1 hold");
    chk("R1 latched", rd_data, 32'h4000_0008);

    // R2 write-one-to-clear, set wins
    step(31'h0000_0020, 1'b1, 3'd0, 32'h0000_0028, 3'd0, "R2");
    chk("R2 set wins", rd_data, 32'h4000_0020);
    step('0, 1'b1, 3'd0, 32'h0, 3'd0, "R2 zero write");
    chk("R2 zero write", rd_data, 32'h4000_0020);

    // R3 masked view and line
    step('0, 1'b1, 3'd1, 32'h0000_0020, 3'd2, "R3");
    chk("R3 masked", rd_data, 32'h0000_0020);
    chk("R3 irq high", {31'h0, irq}, 32'h1);

    // R4 enable zero gates line, raw intact
    step('0, 1'b1, 3'd1, 32'h0, 3'd0, "R4");
    chk("R4 irq low", {31'h0, irq}, 32'h0);
    chk("R4 raw kept", rd_data, 32'h4000_0020);
    clear_raw();

    // R6 threshold 1 and 0
    step(31'h0002_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R6");
    chk("R6 rx every completion", rd_data, 32'h0002_0000);
    step('0, 1'b1, 3'd3, 32'h0000_0001, 3'd3, "R6 thr0");
    step(31'h0008_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R6");
    chk("R6 tx thr 0 as 1", rd_data, 32'h000A_0000);
    clear_raw();

    // R5 count threshold, fields rx[15:0] tx[31:16]
    step('0, 1'b1, 3'd3, 32'h0002_0003, 3'd3, "R5");
    step('0, 1'b1, 3'd4, 32'h0, 3'd4, "R5");
    step('0, 1'b1, 3'd5, 32'h0, 3'd5, "R5");
    step(31'h000A_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R5");
    chk("R5 below thr", rd_data, 32'h0);
    step(31'h0002_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R5");
    chk("R5 rx 2 of 3", rd_data, 32'h0);
    step(31'h000A_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R5");
    chk("R5 both reach", rd_data, 32'h000A_0000);
    clear_raw();

    // R8 no carry over after a hit
    step(31'h0002_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R8");
    step(31'h0002_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R8");
    chk("R8 fresh count", rd_data, 32'h0);
    step(31'h0002_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R8");
    chk("R8 third fires", rd_data, 32'h0002_0000);
    clear_raw();

    // R7 timeout on edge k+T, T=6
    step('0, 1'b1, 3'd3, 32'h0002_0004, 3'd3, "R7");
    step('0, 1'b1, 3'd4, 32'd6, 3'd4, "R7");
    step(31'h0002_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R7");
    idle(5, 3'd0, "R7 wait");
    chk("R7 not before T", rd_data, 32'h0);
    idle(1, 3'd0, "R7");
    chk("R7 timeout bit", rd_data, 32'h1000_0000);
    clear_raw();
    idle(10, 3'd0, "R8 drained");
    chk("R8 no second timeout", rd_data, 32'h0);

    // R9 direct pulses on coalesced timeout positions
    step(31'h3000_0000, 1'b0, 3'd0, 32'h0, 3'd0, "R9");
    chk("R9 no direct set", rd_data, 32'h0);
    step('0, 1'b1, 3'd1, 32'hFFFF_FFFF, 3'd1, "R9");
    chk("R9 bit31 zero", rd_data, 32'h7FFF_FFFF);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [30:0] ev;
      logic        we;
      logic [2:0]  wa;
      logic [31:0] wd;
      ev = 31'($urandom & $urandom & $urandom & $urandom);
      if ($urandom_range(3) == 0) ev[17] = 1'b1;
      if ($urandom_range(3) == 0) ev[19] = 1'b1;
      we = ($urandom_range(7) == 0);
      wa = 3'($urandom_range(5));
      case (wa)
        3'd3: wd = {14'h0, 2'($urandom_range(3)), 14'h0, 2'($urandom_range(3))};
        3'd4, 3'd5: wd = $urandom_range(12);
        default: wd = $urandom;
      endcase
      step(ev, we, wa, wd, 3'($urandom_range(7)), "random R1 R2 R3 R5 R7 R8");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule